// File: doc/BRIEF.md
# Serial 10010 Pattern Detector

This block watches a one-bit serial stream, one bit per clock, and flags each place where the last five bits, oldest first, read 1, 0, 0, 1, 0. The flag is a Mealy output. It rises combinationally in the same cycle that the closing 0 is on the input, so a consumer registers the flag together with that final bit. Occurrences may overlap: the trailing "10" of one match can start the next.

Two interchangeable realisations sit behind the same ports, and a parameter picks one of them. The state-machine form has five named states, encoded in three bits in binary order from 000:
- `ST_IDLE` (000): nothing useful has been seen.
- `ST_1` (001): the stream ends in "1".
- `ST_10` (010): the stream ends in "10".
- `ST_100` (011): the stream ends in "100".
- `ST_1001` (100): the stream ends in "1001".

The transitions for input 0 and input 1 are:

| From | Input 0 | Input 1 |
|------|---------|---------|
| `ST_IDLE` | `ST_IDLE` | `ST_1` |
| `ST_1` | `ST_10` | `ST_1` |
| `ST_10` | `ST_100` | `ST_1` |
| `ST_100` | `ST_IDLE` | `ST_1001` |
| `ST_1001` | `ST_10`, match raised | `ST_1` |

The shift-register form keeps the last four bits together with a saturating fill count. It raises the match when the count is full, the four stored bits equal 1001 and the live bit is 0.

Top module: `serial_pat_detect`

## Requirements
- R1: While `rst` is high, `match_out` is 0. After `rst` is released, `match_out` stays 0 until at least four bits have been accepted.
- R2: When the four bits accepted before the current cycle were 1, 0, 0, 1 (oldest first), none of them was taken while `rst` was high, and `bit_in` is 0, then `match_out` is 1 in that same cycle.
- R3: The output depends on the live input. With the history 1, 0, 0, 1 in place, `bit_in` = 1 holds `match_out` at 0.
- R4: Overlapping occurrences are all reported. The stream 1,0,0,1,0,0,1,0 after reset raises `match_out` on its 5th bit and its 8th bit only.
- R5: A synchronous reset clears the history. The sequence 1,0,0,1, then a reset cycle, then 0 gives no match.
- R6: `match_out` is never 1 unless the current bit and the four accepted bits before it, taken since the last reset, form 10010.
- R7: The state-machine form (`USE_SHIFT`=0) and the shift-register form (`USE_SHIFT`=1) produce the same `match_out` for every input sequence.
- R8: The state-machine form follows the transition table above. Reset enters `ST_IDLE`, and the match is raised only on the 0 input from `ST_1001`, which leads to `ST_10`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; `bit_in` is accepted on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bit_in | input | 1 | Serial data bit for this cycle |
| match_out | output | 1 | High when `bit_in` completes 10010 |

## Verification
On every cycle the assertions tie `match_out` to the actual input history. A match requires the last five bits since reset to be 10010. That pattern forces a match. A live 1 or a history shorter than four bits blocks a match, and reset holds the output low. The equivalence of the two realisations, the overlap behaviour and the clearing by a mid-pattern reset need concrete streams. The bench covers these by sweeping every 10-bit stream after reset and applying directed sequences, with both forms instantiated side by side.

// File: rtl/patdet_pkg.sv
package patdet_pkg;
    // Pattern, oldest bit in the MSB.
    localparam int          PAT_LEN = 5;
    localparam logic [4:0]  PATTERN = 5'b10010;
    localparam int          HIST_W  = PAT_LEN - 1;
    localparam int          FILL_W  = $clog2(PAT_LEN);

    // Plain binary state assignment starting at 000.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_1    = 3'd1,
        ST_10   = 3'd2,
        ST_100  = 3'd3,
        ST_1001 = 3'd4
    } pd_state_e;
endpackage

// File: rtl/patdet_fsm.sv
module patdet_fsm
    import patdet_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bit_in,
    output logic match_out
);
    pd_state_e state_q;
    pd_state_e state_d;
    logic      hit;

    // State register.
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Next state and Mealy output.
    always_comb begin
        state_d = ST_IDLE;
        hit     = 1'b0;
        unique case (state_q)
            ST_IDLE: state_d = bit_in ? ST_1 : ST_IDLE;
            ST_1:    state_d = bit_in ? ST_1 : ST_10;
            ST_10:   state_d = bit_in ? ST_1 : ST_100;
            ST_100:  state_d = bit_in ? ST_1001 : ST_IDLE;
            ST_1001: begin
                if (bit_in) begin
                    state_d = ST_1;
                end else begin
                    state_d = ST_10;
                    hit     = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign match_out = hit & ~rst;
endmodule

// File: rtl/patdet_shreg.sv
module patdet_shreg
    import patdet_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bit_in,
    output logic match_out
);
    localparam logic [FILL_W-1:0] FULL = FILL_W'(HIST_W);

    logic [HIST_W-1:0] hist_q;
    logic [FILL_W-1:0] fill_q;
    logic              full;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
            fill_q <= '0;
        end else begin
            hist_q <= {hist_q[HIST_W-2:0], bit_in};
            if (fill_q != FULL) fill_q <= fill_q + 1'b1;
        end
    end

    assign full      = (fill_q == FULL);
    assign match_out = ~rst & full
                     & (hist_q == PATTERN[PAT_LEN-1:1])
                     & (bit_in == PATTERN[0]);
endmodule

// File: rtl/serial_pat_detect.sv
module serial_pat_detect #(
    parameter bit USE_SHIFT = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_in,
    output logic match_out
);
    generate
        if (USE_SHIFT) begin : g_shreg
            patdet_shreg u_core (
                .clk       (clk),
                .rst       (rst),
                .bit_in    (bit_in),
                .match_out (match_out)
            );
        end else begin : g_fsm
            patdet_fsm u_core (
                .clk       (clk),
                .rst       (rst),
                .bit_in    (bit_in),
                .match_out (match_out)
            );
        end
    endgenerate
endmodule

// File: rtl/serial_pat_detect_chk.sv
module serial_pat_detect_chk (
    input logic clk,
    input logic rst,
    input logic bit_in,
    input logic match_out
);
    // Bits accepted since reset, saturating at 4.
    logic [2:0] seen_q;
    always_ff @(posedge clk) begin
        if (rst)                 seen_q <= 3'd0;
        else if (seen_q != 3'd4) seen_q <= seen_q + 3'd1;
    end

    // R1
    a_r1_quiet_in_reset: assert property (@(posedge clk) rst |-> !match_out);

    // R1
    a_r1_not_early: assert property (@(posedge clk) disable iff (rst)
        (seen_q < 3'd4) |-> !match_out);

    // R3
    a_r3_one_blocks: assert property (@(posedge clk) disable iff (rst)
        bit_in |-> !match_out);

    // R6
    a_r6_needs_pattern: assert property (@(posedge clk) disable iff (rst)
        match_out |-> (seen_q == 3'd4 && !bit_in && $past(bit_in, 1)
                       && !$past(bit_in, 2) && !$past(bit_in, 3) && $past(bit_in, 4)));

    // R2
    a_r2_pattern_hits: assert property (@(posedge clk) disable iff (rst)
        (seen_q == 3'd4 && !bit_in && $past(bit_in, 1) && !$past(bit_in, 2)
         && !$past(bit_in, 3) && $past(bit_in, 4)) |-> match_out);
endmodule

bind serial_pat_detect serial_pat_detect_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bit_in    (bit_in),
    .match_out (match_out)
);

// File: tb/serial_pat_detect_test.sv
`timescale 1ns/1ps
module serial_pat_detect_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_in = 1'b0;
    logic m_fsm;
    logic m_sr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [3:0] past;
    int         nfill;

    always #2.5 clk = ~clk;

    serial_pat_detect #(.USE_SHIFT(1'b0)) uut (
        .clk(clk), .rst(rst), .bit_in(bit_in), .match_out(m_fsm));
    serial_pat_detect #(.USE_SHIFT(1'b1)) uut_sr (
        .clk(clk), .rst(rst), .bit_in(bit_in), .match_out(m_sr));

    task automatic check(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
        end
    endtask

    // Reset for one edge, checking R1 while asserted.
    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        bit_in = 1'b0;
        #1;
        check(m_fsm, 1'b0, "R1");
        check(m_sr, 1'b0, "R1");
        @(posedge clk);
        past = 4'b0;
        nfill = 0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    // Apply one bit, compare Mealy output before the edge, then update model.
    task automatic step(input logic b, input string req, output logic got);
        logic exp;
        if (clk) @(negedge clk);
        bit_in = b;
        #1;
        exp = (nfill >= 4) && ({past, b} == 5'b10010);
        check(m_fsm, exp, req);
        check(m_sr, exp, req);
        check(m_sr, m_fsm, "R7");
        got = m_fsm;
        @(posedge clk);
        past = {past[2:0], b};
        nfill++;
        @(negedge clk);
    endtask

    initial begin
        logic g;
        int   hits;
        do_reset();
        check(m_fsm, 1'b0, "R1");

        // R4: overlapping stream 10010010
        begin
            logic [7:0] s;
            s = 8'b10010010;
            hits = 0;
            for (int i = 7; i >= 0; i--) begin
                step(s[i], "R4", g);
                if (g) hits++;
            end
            check(hits == 2, 1'b1, "R4");
        end

        // R3: history 1001 with a live 1 gives no match
        do_reset();
        step(1'b1, "R3", g); step(1'b0, "R3", g);
        step(1'b0, "R3", g); step(1'b1, "R3", g);
        step(1'b1, "R3", g);
        check(g, 1'b0, "R3");

        // R5: reset in the middle of the pattern
        do_reset();
        step(1'b1, "R5", g); step(1'b0, "R5", g);
        step(1'b0, "R5", g); step(1'b1, "R5", g);
        do_reset();
        step(1'b0, "R5", g);
        check(g, 1'b0, "R5");

        // R8: ST_1001 on 0 goes to ST_10, so "10010" then "010" matches again
        do_reset();
        step(1'b1, "R8", g); step(1'b0, "R8", g); step(1'b0, "R8", g);
        step(1'b1, "R8", g); step(1'b0, "R8", g);
        check(g, 1'b1, "R8");
        step(1'b0, "R8", g); step(1'b1, "R8", g); step(1'b0, "R8", g);
        check(g, 1'b1, "R8");

        // R2/R6/R7: every 10-bit stream after reset
        for (int seq = 0; seq < 1024; seq++) begin
            logic [9:0] v;
            v = 10'(seq);
            do_reset();
            for (int i = 9; i >= 0; i--) begin
                logic e;
                e = (nfill >= 4) && ({past, v[i]} == 5'b10010);
                step(v[i], e ? "R2" : "R6", g);
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #900000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule